// File: doc/BRIEF.md
# 1553 Manchester Word Decoder

This block turns the serial Manchester II stream from a MIL-STD-1553 receiver front end into 20-bit-time words. The front end gives two lines, `rx_p` and `rx_n`. `rx_p` high means the bus is positive, `rx_n` high means it is negative, and both low means the bus is idle. The decoder samples these lines on both clock edges, so it takes two samples per clock period. At a clock of `CLK_MHZ` MHz and 1 Mbit/s, one bit time is `2*CLK_MHZ` samples. The clock may be 10, 12, 16 or 20 MHz.

A word starts with a sync of three bit times and ends with 16 data bits and an odd-parity bit. A good word gives a one-cycle `word_valid` pulse, together with the data and a flag that tells whether the sync was a command/status sync or a data sync. A bad word gives a one-cycle `word_err` pulse, and one error flag names the cause. A one-cycle `mid_parity` strobe marks the middle of the parity bit, so that later command logic can time its checks from it. After any word, good or bad, the decoder goes back to looking for the next sync. This allows words to follow each other with no gap.

Top module: `manchester_word_decoder`

## Requirements
- R1: Both clock edges sample the line. A word whose line transitions fall midway between rising edges decodes to the same data and sync type as a word whose transitions fall midway between falling edges.
- R2: A sync is a non-idle level held for between 1.25 and 2.25 bit times, followed by the opposite level. If the leading level is high (`rx_p`), `sync_cmd` is 1 (command/status). If it is low (`rx_n`), `sync_cmd` is 0 (data). Shorter or longer runs produce no output.
- R3: A logic 1 is high then low, and a logic 0 is low then high. The first data bit received lands in `rx_data[15]`. `word_valid` is a one-cycle pulse. `rx_data` and `sync_cmd` change only with `word_valid`.
- R4: If the second half of the sync is not the opposite level at its midpoint, `word_err` fires with `err_flags` = 4'b1000 (sync error).
- R5: A bit whose two halves are the same level, or that shows both lines high, raises `word_err` with `err_flags` = 4'b0100 (encoding error).
- R6: Parity is odd over the 16 data bits and the parity bit. An even total raises `word_err` with `err_flags` = 4'b0010, and `rx_data` keeps its old value.
- R7: An idle line (both lines low) in either half of a bit before the parity bit has been decoded raises `word_err` with `err_flags` = 4'b0001 (bit count error).
- R8: `mid_parity` pulses for one cycle half a bit time into the parity bit, before `word_valid`. It pulses only for words that reach the parity bit.
- R9: A sync that starts right after the parity bit of the word before it is detected, so both words decode.
- R10: After any error, the decoder looks for a sync again and decodes the next good word.
- R11: On `word_err`, exactly one bit of `err_flags` is set, and the flags hold until the next `word_err`. `word_valid` and `word_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Both edges sample the line. |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_p | input | 1 | Receiver output that is high while the bus is positive |
| rx_n | input | 1 | Receiver output that is high while the bus is negative |
| rx_data | output | 16 | Data of the last good word. The first bit received is in bit 15. |
| sync_cmd | output | 1 | Sync type of the last good word: 1 for command/status, 0 for data |
| word_valid | output | 1 | One-cycle pulse when a good word is complete |
| word_err | output | 1 | One-cycle pulse when a word is rejected |
| err_flags | output | 4 | Cause of the last rejected word: [3] sync, [2] encoding, [1] parity, [0] bit count |
| mid_parity | output | 1 | One-cycle strobe in the middle of the parity bit |

## Verification
Two things can happen in the same clock cycle: the decision on one word's parity bit, and the start of the run count for the next word's sync. This is because each clock carries two samples, and the decoder returns to sync hunting partway through that pair. The bench provokes this by sending a data word whose parity bit ends high, and then, with no idle gap, a command word whose sync also starts high. The trailing half of the parity bit then joins the sync run. The result is judged by both words arriving with their own data and sync types, in order.

// File: rtl/manchester_word_decoder.sv
module manchester_word_decoder #(
  parameter int CLK_MHZ = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_p,
  input  logic        rx_n,
  output logic [15:0] rx_data,
  output logic        sync_cmd,
  output logic        word_valid,
  output logic        word_err,
  output logic [3:0]  err_flags,
  output logic        mid_parity
);

  localparam int S        = 2 * CLK_MHZ;
  localparam int H        = S / 2;
  localparam int Q1       = S / 4;
  localparam int Q3       = 3 * S / 4;
  localparam int SYNC_LEN = 3 * H;
  localparam int RUN_MIN  = S + Q1;
  localparam int RUN_MAX  = 2 * S + Q1;
  localparam int CW       = $clog2(SYNC_LEN);
  localparam int RW       = $clog2(RUN_MAX + 2);

  logic [1:0]    s_fall;
  logic          in_q, n_in, was_in;
  logic [1:0]    lvl_q, n_lvl, h1_q, n_h1, x;
  logic [RW-1:0] run_q, n_run;
  logic [CW-1:0] cnt_q, n_cnt;
  logic [4:0]    seg_q, n_seg;
  logic [15:0]   sh_q, n_sh, vdat;
  logic          cmd_q, n_cmd, vcmd, bitv, v, e, m;
  logic [3:0]    ef;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) s_fall <= 2'b00;
    else        s_fall <= {rx_p, rx_n};

  always_comb begin
    n_in = in_q; n_lvl = lvl_q; n_run = run_q; n_cnt = cnt_q; n_seg = seg_q;
    n_h1 = h1_q; n_sh = sh_q; n_cmd = cmd_q;
    v = 1'b0; e = 1'b0; m = 1'b0; ef = 4'b0000; vdat = sh_q; vcmd = cmd_q;
    x = 2'b00; bitv = 1'b0; was_in = 1'b0;
    for (int i = 0; i < 2; i++) begin
      x = (i == 0) ? s_fall : {rx_p, rx_n};
      was_in = n_in;
      if (!n_in) begin
        if (x == 2'b10 || x == 2'b01) begin
          if (x == n_lvl) begin
            if (n_run != RW'(RUN_MAX + 1)) n_run = n_run + RW'(1);
          end else begin
            if ((n_lvl == 2'b10 || n_lvl == 2'b01) &&
                n_run >= RW'(RUN_MIN) && n_run <= RW'(RUN_MAX)) begin
              n_in = 1'b1; n_cmd = (n_lvl == 2'b10); n_seg = 5'd0; n_cnt = CW'(1);
            end
            n_run = RW'(1);
          end
        end else begin
          n_run = '0;
        end
        n_lvl = x;
      end else if (n_seg == 5'd0) begin
        if (n_cnt == CW'(H) && x != (n_cmd ? 2'b01 : 2'b10)) begin
          n_in = 1'b0; e = 1'b1; ef = 4'b1000;
        end else if (n_cnt == CW'(SYNC_LEN - 1)) begin
          n_seg = 5'd1; n_cnt = '0;
        end else begin
          n_cnt = n_cnt + CW'(1);
        end
      end else begin
        if (n_cnt == CW'(Q1)) n_h1 = x;
        if (n_seg == 5'd17 && n_cnt == CW'(H)) m = 1'b1;
        if (n_cnt == CW'(Q3)) begin
          bitv = (n_h1 == 2'b10);
          if (n_h1 == 2'b00 || x == 2'b00) begin
            n_in = 1'b0; e = 1'b1; ef = 4'b0001;
          end else if (n_h1 == x || n_h1 == 2'b11 || x == 2'b11) begin
            n_in = 1'b0; e = 1'b1; ef = 4'b0100;
          end else if (n_seg == 5'd17) begin
            n_in = 1'b0;
            if (^{n_sh, bitv}) begin v = 1'b1; vdat = n_sh; vcmd = n_cmd; end
            else begin e = 1'b1; ef = 4'b0010; end
          end else begin
            n_sh = {n_sh[14:0], bitv};
          end
        end
        if (n_in) begin
          if (n_cnt == CW'(S - 1)) begin n_seg = n_seg + 5'd1; n_cnt = '0; end
          else n_cnt = n_cnt + CW'(1);
        end
      end
      if (was_in && !n_in) begin
        n_lvl = x;
        n_run = (x == 2'b10 || x == 2'b01) ? RW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_q <= 1'b0; lvl_q <= 2'b00; run_q <= '0; cnt_q <= '0; seg_q <= 5'd0;
      h1_q <= 2'b00; sh_q <= 16'h0000; cmd_q <= 1'b0;
      rx_data <= 16'h0000; sync_cmd <= 1'b0; word_valid <= 1'b0;
      word_err <= 1'b0; err_flags <= 4'b0000; mid_parity <= 1'b0;
    end else begin
      in_q <= n_in; lvl_q <= n_lvl; run_q <= n_run; cnt_q <= n_cnt; seg_q <= n_seg;
      h1_q <= n_h1; sh_q <= n_sh; cmd_q <= n_cmd;
      word_valid <= v; word_err <= e; mid_parity <= m;
      if (v) begin rx_data <= vdat; sync_cmd <= vcmd; end
      if (e) err_flags <= ef;
    end

  logic mid_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       mid_seen <= 1'b0;
    else if (word_valid || word_err)  mid_seen <= 1'b0;
    else if (mid_parity)              mid_seen <= 1'b1;

  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && word_err)); // R11
  AST_ONE_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    word_err |-> $countones(err_flags) == 1); // R11
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_err |-> $stable(err_flags)); // R11
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(rx_data) && $stable(sync_cmd))); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R3
  AST_MID_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> mid_seen); // R8

endmodule

// File: tb/tb_manchester_word_decoder.sv
`timescale 1ns/1ps
module tb_manchester_word_decoder;
  localparam int CLK_PERIOD = 100;
  localparam int SLOT       = CLK_PERIOD / 2;
  localparam int BIT_SLOTS  = 20;
  localparam int HB         = BIT_SLOTS / 2;
  localparam int M_OK = 0, M_PAR = 1, M_ENC = 2, M_TRUNC = 3, M_SYNC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rxl = 2'b00;
  logic [15:0] rx_data;
  logic sync_cmd, word_valid, word_err, mid_parity;
  logic [3:0] err_flags;

  manchester_word_decoder dut (
    .clk(clk), .rst_n(rst_n), .rx_p(rxl[1]), .rx_n(rxl[0]),
    .rx_data(rx_data), .sync_cmd(sync_cmd), .word_valid(word_valid),
    .word_err(word_err), .err_flags(err_flags), .mid_parity(mid_parity));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int n_valid = 0, n_err = 0, n_mid = 0, order_bad = 0;
  bit mid_since = 1'b0;
  logic [15:0] last_data = 16'h0, prev_data = 16'h0;
  logic last_cmd = 1'b0;
  logic [3:0] last_flags = 4'h0;

  always @(negedge clk) if (rst_n) begin
    if (mid_parity) begin n_mid++; mid_since = 1'b1; end
    if (word_valid) begin
      n_valid++; if (!mid_since) order_bad++;
      prev_data = last_data; last_data = rx_data; last_cmd = sync_cmd; mid_since = 1'b0;
    end
    if (word_err) begin n_err++; last_flags = err_flags; mid_since = 1'b0; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] c, input int n);
    rxl = c;
    if (n > 0) #(SLOT * n);
  endtask

  task automatic send_word(input bit cmd, input logic [15:0] d, input int mode, input int gap);
    logic [1:0] a, b;
    logic p, bv;
    bit stop;
    a = cmd ? 2'b10 : 2'b01;
    b = cmd ? 2'b01 : 2'b10;
    stop = 1'b0;
    put(a, 3 * HB);
    if (mode == M_SYNC) begin put(b, 5); put(2'b00, 3 * HB - 5); end
    else put(b, 3 * HB);
    p = (mode == M_PAR) ? ^d : ~^d;
    for (int i = 0; i < 17; i++) begin
      if (!stop) begin
        bv = (i < 16) ? d[15 - i] : p;
        if (mode == M_ENC && i == 5) put(2'b10, BIT_SLOTS);
        else if (mode == M_TRUNC && i == 8) begin put(2'b00, BIT_SLOTS * (17 - i)); stop = 1'b1; end
        else if (bv) begin put(2'b10, HB); put(2'b01, HB); end
        else begin put(2'b01, HB); put(2'b10, HB); end
      end
    end
    if (gap > 0) put(2'b00, gap);
  endtask

  task automatic t_reset;
    check(word_valid == 1'b0 && word_err == 1'b0 && mid_parity == 1'b0, "R3 reset pulses",
          {word_valid, word_err, mid_parity}, 0);
    check(rx_data == 16'h0 && err_flags == 4'h0 && sync_cmd == 1'b0, "R11 reset state",
          {rx_data, err_flags, sync_cmd}, 0);
  endtask

  task automatic t_basic;
    int v0;
    v0 = n_valid;
    send_word(1'b1, 16'hC35A, M_OK, 40);
    check(n_valid == v0 + 1, "R3 one valid per word", n_valid - v0, 1);
    check(last_data == 16'hC35A, "R3 data msb first", last_data, 16'hC35A);
    check(last_cmd == 1'b1, "R2 command sync type", last_cmd, 1);
    send_word(1'b0, 16'h0F81, M_OK, 40);
    check(last_data == 16'h0F81 && last_cmd == 1'b0, "R2 data sync type",
          {last_data, 3'b0, last_cmd}, {16'h0F81, 4'h0});
    check(order_bad == 0, "R8 mid strobe before valid", order_bad, 0);
  endtask

  task automatic t_align;
    logic [15:0] d1;
    put(2'b00, 1);
    send_word(1'b1, 16'h5AA5, M_OK, 40);
    d1 = last_data;
    put(2'b00, 1);
    send_word(1'b1, 16'h5AA5, M_OK, 40);
    check(d1 == 16'h5AA5 && last_data == 16'h5AA5 && last_cmd == 1'b1,
          "R1 both edge phases decode", {d1, last_data}, {16'h5AA5, 16'h5AA5});
  endtask

  task automatic t_noise;
    int v0, e0;
    v0 = n_valid; e0 = n_err;
    put(2'b10, BIT_SLOTS); put(2'b01, BIT_SLOTS); put(2'b00, 40);
    put(2'b10, 3 * BIT_SLOTS); put(2'b01, 3 * HB); put(2'b00, 40);
    check(n_valid == v0 && n_err == e0, "R2 short and long runs ignored",
          {n_valid - v0, n_err - e0}, 0);
  endtask

  task automatic t_parity;
    int m0, e0;
    send_word(1'b0, 16'h1234, M_OK, 40);
    m0 = n_mid; e0 = n_err;
    send_word(1'b0, 16'h00FF, M_PAR, 40);
    check(n_err == e0 + 1 && last_flags == 4'b0010, "R6 parity error flag", last_flags, 4'b0010);
    check(last_data == 16'h1234, "R3 data held on error", last_data, 16'h1234);
    check(n_mid == m0 + 1, "R8 mid strobe on parity-failed word", n_mid - m0, 1);
  endtask

  task automatic t_enc;
    int v0;
    v0 = n_valid;
    send_word(1'b1, 16'h0800, M_ENC, 40);
    check(last_flags == 4'b0100 && n_valid == v0, "R5 encoding error flag", last_flags, 4'b0100);
  endtask

  task automatic t_count;
    int m0;
    m0 = n_mid;
    send_word(1'b0, 16'hFFFF, M_TRUNC, 40);
    check(last_flags == 4'b0001, "R7 bit count error flag", last_flags, 4'b0001);
    check(n_mid == m0, "R8 no mid strobe on short word", n_mid - m0, 0);
  endtask

  task automatic t_sync;
    int e0;
    e0 = n_err;
    send_word(1'b1, 16'h2468, M_SYNC, 40);
    check(n_err == e0 + 1 && last_flags == 4'b1000, "R4 sync error flag", last_flags, 4'b1000);
    send_word(1'b1, 16'h9BDF, M_OK, 40);
    check(last_data == 16'h9BDF && last_cmd == 1'b1, "R10 recovery after error", last_data, 16'h9BDF);
    check(n_err == e0 + 1, "R11 one error per bad word", n_err - e0, 1);
  endtask

  task automatic t_b2b;
    int v0;
    v0 = n_valid;
    send_word(1'b0, 16'h0001, M_OK, 0);
    send_word(1'b1, 16'hBEEF, M_OK, 40);
    check(n_valid == v0 + 2, "R9 back-to-back count", n_valid - v0, 2);
    check(prev_data == 16'h0001 && last_data == 16'hBEEF && last_cmd == 1'b1,
          "R9 back-to-back data", {prev_data, last_data}, {16'h0001, 16'hBEEF});
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD / 4);
    put(2'b00, 6);
    rst_n = 1'b1;
    put(2'b00, 10);
    t_reset();
    t_basic();
    t_align();
    t_noise();
    t_parity();
    t_enc();
    t_count();
    t_sync();
    t_b2b();
    finish_run();
  end
endmodule